// File: doc/BRIEF.md
# Blocking Dual-Port Memory Forwarder

This block sits between a processor core and a memory bus. The core reaches it through two requester ports, one for instruction fetch and one for data. The bus is reached through a single memory port. The block forwards one transaction at a time. It tags each forwarded packet with the port it came from, and uses that tag to send the matching response back to the right requester.

No channel uses ready back-pressure. A sender offers a packet for one cycle, and the receiver accepts or refuses it within that cycle. The sender keeps any packet that was refused. It may offer that packet again only after the receiver has sent a one-cycle retry pulse.

Inside the block there are three places that hold packets. The first is the memory side, which keeps a packet the bus refused until the bus sends a retry. The second and third are the two requester response slots, each of which keeps a response the requester refused until that requester sends a retry. A per-port flag records that a request was refused. Once the block is free again, it tells each such requester that it may resend.

Top module: `dual_req_forwarder`

## Requirements
- R1: While reset is low, and after it is released with no traffic, every valid, accept and retry output is 0.
- R2: If the block is idle, a request offered on either requester port is accepted in the same cycle. In the next cycle it appears on the memory port with its address, command and data unchanged. The fetch-tag bit is 1 if the request came from the instruction port and 0 if it came from the data port.
- R3: A request offered while a transaction is outstanding is refused in the same cycle, and the block marks that port as owed a retry.
- R4: If both requester ports offer a request in the same idle cycle, the instruction port is accepted and the data port is refused.
- R5: Suppose the bus refuses a forwarded packet. The memory port then drives no packet until the bus raises its retry input. The held packet is offered again, unchanged, in the cycle after that retry, and it can be refused again any number of times.
- R6: A memory response frees the block in the cycle it arrives, so a request offered in that same cycle is accepted.
- R7: A memory response with fetch tag 1 goes to the instruction port, and one with fetch tag 0 goes to the data port. It appears there one cycle after it arrives, with address and data kept. Command encoding: bit 0 means write and bit 1 means response. The forwarded command has bit 1 set and bit 0 kept.
- R8: If a requester refuses a response, that port drives no response until the requester pulses its response-retry input. The same response is offered again in the next cycle.
- R9: A request-retry output is a one-cycle pulse. It fires only when three conditions hold: the block is not busy, that port was refused earlier, and that port has no response waiting to be delivered or held. A port that was never refused gets no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fch_req_valid | input | 1 | Instruction port offers a request this cycle |
| fch_req_addr | input | ADDR_W | Instruction request address |
| fch_req_cmd | input | 2 | Instruction request command (bit0 write) |
| fch_req_data | input | DATA_W | Instruction request data |
| fch_req_accept | output | 1 | Instruction request accepted this cycle |
| fch_req_retry | output | 1 | Instruction port may resend a refused request |
| fch_rsp_valid | output | 1 | Response offered to instruction port |
| fch_rsp_addr | output | ADDR_W | Response address |
| fch_rsp_cmd | output | 2 | Response command |
| fch_rsp_data | output | DATA_W | Response data |
| fch_rsp_accept | input | 1 | Instruction requester accepts the response |
| fch_rsp_retry | input | 1 | Instruction requester can now take the held response |
| dat_req_valid | input | 1 | Data port offers a request this cycle |
| dat_req_addr | input | ADDR_W | Data request address |
| dat_req_cmd | input | 2 | Data request command |
| dat_req_data | input | DATA_W | Data request data |
| dat_req_accept | output | 1 | Data request accepted this cycle |
| dat_req_retry | output | 1 | Data port may resend a refused request |
| dat_rsp_valid | output | 1 | Response offered to data port |
| dat_rsp_addr | output | ADDR_W | Response address |
| dat_rsp_cmd | output | 2 | Response command |
| dat_rsp_data | output | DATA_W | Response data |
| dat_rsp_accept | input | 1 | Data requester accepts the response |
| dat_rsp_retry | input | 1 | Data requester can now take the held response |
| mem_req_valid | output | 1 | Packet offered to the bus |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_cmd | output | 2 | Forwarded command |
| mem_req_ifetch | output | 1 | Fetch tag of the forwarded packet |
| mem_req_data | output | DATA_W | Forwarded data |
| mem_req_accept | input | 1 | Bus accepts the offered packet |
| mem_req_retry | input | 1 | Bus can now take the held packet |
| mem_rsp_valid | input | 1 | Response from the bus (always accepted) |
| mem_rsp_addr | input | ADDR_W | Response address |
| mem_rsp_cmd | input | 2 | Response command as returned |
| mem_rsp_ifetch | input | 1 | Fetch tag echoed by the bus |
| mem_rsp_data | input | DATA_W | Response data |

## Verification
Suppose the busy flag is stuck, or is cleared late. The first symptom is at the requester ports: an accept or a retry pulse goes missing in the very cycle a response arrives, or in the cycle after it. A wrong held-packet state shows up at the memory port within one cycle of a bus refusal or retry. It appears as an extra offer, a missing offer, or a changed packet. A routing or conversion fault appears one cycle after the memory response, as a response on the wrong port or with a wrong command. A need-retry flag that is lost or left set shows up as a missing or repeated retry pulse in the first free cycle after the port's response drains.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    // Requester port indices; the lower index wins arbitration.
    localparam int PORT_FCH = 0;
    localparam int PORT_DAT = 1;
    localparam int NUM_REQ  = 2;
    localparam int CMD_W    = 2;

    // Command encoding: bit0 = write, bit1 = response.
    localparam logic [CMD_W-1:0] CMD_RD_REQ = 2'b00;
    localparam logic [CMD_W-1:0] CMD_WR_REQ = 2'b01;
    localparam logic [CMD_W-1:0] CMD_RSP    = 2'b10;

    // State of a one-packet outgoing channel.
    typedef enum logic [1:0] {
        TX_EMPTY = 2'd0,
        TX_SEND  = 2'd1,
        TX_HELD  = 2'd2
    } tx_state_e;

    // Turn a request command into its response form.
    function automatic logic [CMD_W-1:0] to_rsp(input logic [CMD_W-1:0] c);
        return c | CMD_RSP;
    endfunction
endpackage

// File: rtl/fwd_ctrl.sv
// Request admission control.
// Keeps the busy flag, arbitrates between requester ports with a fixed
// priority (lowest index wins), tracks a needs-retry flag per port and
// produces the retry pulses. Assumes a memory response only arrives while
// busy; that response frees the block in the same cycle.
module fwd_ctrl #(
    parameter int NPORT = 2,
    parameter int PKT_W = 51
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             req_valid_i,
    input  logic [NPORT-1:0][PKT_W-1:0]  req_pkt_i,
    input  logic                         rsp_arrive_i,
    input  logic [NPORT-1:0]             rsp_occ_i,
    output logic [NPORT-1:0]             req_accept_o,
    output logic [NPORT-1:0]             req_retry_o,
    output logic                         fwd_load_o,
    output logic [PKT_W-1:0]             fwd_pkt_o,
    output logic                         busy_o
);
    logic             busy_q;
    logic             free;
    logic [NPORT-1:0] grant;
    logic [NPORT-1:0] need_q;

    // Block can admit a request when idle or when the response lands now.
    assign free = !busy_q || rsp_arrive_i;

    // Fixed-priority grant and forwarded packet selection.
    always_comb begin
        grant     = '0;
        fwd_pkt_o = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (free && req_valid_i[i] && (grant == '0)) begin
                grant[i]  = 1'b1;
                fwd_pkt_o = req_pkt_i[i];
            end
        end
    end

    assign req_accept_o = grant;
    assign fwd_load_o   = |grant;
    assign busy_o       = busy_q;

    // Busy flag: set by an accepted request, cleared by a memory response.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= 1'b0;
        else if (|grant)     busy_q <= 1'b1;
        else if (rsp_arrive_i) busy_q <= 1'b0;
    end

    // Per-port needs-retry flag and retry pulse.
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign req_retry_o[g] = !busy_q && need_q[g] && !rsp_occ_i[g];

        // Flag set on refusal, cleared when the pulse goes out.
        always_ff @(posedge clk) begin
            if (!rst_n)                               need_q[g] <= 1'b0;
            else if (req_valid_i[g] && !grant[g])     need_q[g] <= 1'b1;
            else if (req_retry_o[g])                  need_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/fwd_mem_tx.sv
// Memory-side sender with a single blocked-packet register.
// A loaded packet is offered the next cycle; if refused it is held and
// offered again only in the cycle after a retry from the bus. Assumes no
// new packet is loaded while one is held.
module fwd_mem_tx
    import fwd_pkg::*;
#(
    parameter int PKT_W = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PKT_W-1:0] pkt_i,
    output logic             valid_o,
    output logic [PKT_W-1:0] pkt_o,
    input  logic             accept_i,
    input  logic             retry_i,
    output logic             held_o
);
    tx_state_e        state_q;
    logic [PKT_W-1:0] pkt_q;

    assign valid_o = (state_q == TX_SEND);
    assign held_o  = (state_q == TX_HELD);
    assign pkt_o   = pkt_q;

    // Channel state: offer, hold on refusal, release the hold on retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
        end else if (load_i) begin
            state_q <= TX_SEND;
        end else begin
            case (state_q)
                TX_SEND: state_q <= accept_i ? TX_EMPTY : TX_HELD;
                TX_HELD: if (retry_i) state_q <= TX_SEND;
                default: state_q <= TX_EMPTY;
            endcase
        end
    end

    // Packet register: captured on load, kept while offered or held.
    always_ff @(posedge clk) begin
        if (!rst_n)      pkt_q <= '0;
        else if (load_i) pkt_q <= pkt_i;
    end
endmodule

// File: rtl/fwd_rsp_tx.sv
// Requester-side response sender for one port.
// Stores a response routed to this port, converts its command to the
// response form, offers it the next cycle and holds it after a refusal
// until the requester pulses retry. Assumes at most one response in flight.
module fwd_rsp_tx
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o,
    input  logic              accept_i,
    input  logic              retry_i,
    output logic              occ_o
);
    tx_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] data_q;

    assign valid_o = (state_q == TX_SEND);
    assign occ_o   = (state_q != TX_EMPTY);
    assign addr_o  = addr_q;
    assign cmd_o   = cmd_q;
    assign data_o  = data_q;

    // Channel state for the response slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
        end else if (load_i) begin
            state_q <= TX_SEND;
        end else begin
            case (state_q)
                TX_SEND: state_q <= accept_i ? TX_EMPTY : TX_HELD;
                TX_HELD: if (retry_i) state_q <= TX_SEND;
                default: state_q <= TX_EMPTY;
            endcase
        end
    end

    // Response storage with command conversion on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            data_q <= '0;
        end else if (load_i) begin
            addr_q <= addr_i;
            cmd_q  <= to_rsp(cmd_i);
            data_q <= data_i;
        end
    end
endmodule

// File: rtl/dual_req_forwarder.sv
// Blocking forwarder between two requester ports and one memory port.
// Admits one transaction at a time, forwards it with a fetch tag, and
// returns the response to the port named by the tag. Every channel uses
// offer/accept with retry pulses; senders keep refused packets.
module dual_req_forwarder
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fch_req_valid,
    input  logic [ADDR_W-1:0] fch_req_addr,
    input  logic [1:0]        fch_req_cmd,
    input  logic [DATA_W-1:0] fch_req_data,
    output logic              fch_req_accept,
    output logic              fch_req_retry,
    output logic              fch_rsp_valid,
    output logic [ADDR_W-1:0] fch_rsp_addr,
    output logic [1:0]        fch_rsp_cmd,
    output logic [DATA_W-1:0] fch_rsp_data,
    input  logic              fch_rsp_accept,
    input  logic              fch_rsp_retry,
    input  logic              dat_req_valid,
    input  logic [ADDR_W-1:0] dat_req_addr,
    input  logic [1:0]        dat_req_cmd,
    input  logic [DATA_W-1:0] dat_req_data,
    output logic              dat_req_accept,
    output logic              dat_req_retry,
    output logic              dat_rsp_valid,
    output logic [ADDR_W-1:0] dat_rsp_addr,
    output logic [1:0]        dat_rsp_cmd,
    output logic [DATA_W-1:0] dat_rsp_data,
    input  logic              dat_rsp_accept,
    input  logic              dat_rsp_retry,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_cmd,
    output logic              mem_req_ifetch,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_req_accept,
    input  logic              mem_req_retry,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [1:0]        mem_rsp_cmd,
    input  logic              mem_rsp_ifetch,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int PKT_W = 1 + CMD_W + ADDR_W + DATA_W;

    logic [NUM_REQ-1:0]            req_valid;
    logic [NUM_REQ-1:0][PKT_W-1:0] req_pkt;
    logic [NUM_REQ-1:0]            req_accept;
    logic [NUM_REQ-1:0]            req_retry;
    logic [NUM_REQ-1:0]            rsp_occ;
    logic [NUM_REQ-1:0]            rsp_load;
    logic [NUM_REQ-1:0]            rsp_valid;
    logic [NUM_REQ-1:0]            rsp_accept;
    logic [NUM_REQ-1:0]            rsp_retry;
    logic [NUM_REQ-1:0][ADDR_W-1:0] rsp_addr;
    logic [NUM_REQ-1:0][CMD_W-1:0]  rsp_cmd;
    logic [NUM_REQ-1:0][DATA_W-1:0] rsp_data;
    logic                          fwd_load;
    logic [PKT_W-1:0]              fwd_pkt;
    logic [PKT_W-1:0]              mem_pkt;
    logic                          mem_held;
    logic                          busy;

    // Gather requester ports; the fetch tag is set by port identity.
    assign req_valid[PORT_FCH] = fch_req_valid;
    assign req_valid[PORT_DAT] = dat_req_valid;
    assign req_pkt[PORT_FCH]   = {1'b1, fch_req_cmd, fch_req_addr, fch_req_data};
    assign req_pkt[PORT_DAT]   = {1'b0, dat_req_cmd, dat_req_addr, dat_req_data};
    assign fch_req_accept      = req_accept[PORT_FCH];
    assign dat_req_accept      = req_accept[PORT_DAT];
    assign fch_req_retry       = req_retry[PORT_FCH];
    assign dat_req_retry       = req_retry[PORT_DAT];

    fwd_ctrl #(
        .NPORT (NUM_REQ),
        .PKT_W (PKT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_pkt_i    (req_pkt),
        .rsp_arrive_i (mem_rsp_valid),
        .rsp_occ_i    (rsp_occ),
        .req_accept_o (req_accept),
        .req_retry_o  (req_retry),
        .fwd_load_o   (fwd_load),
        .fwd_pkt_o    (fwd_pkt),
        .busy_o       (busy)
    );

    fwd_mem_tx #(
        .PKT_W (PKT_W)
    ) u_mem_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (fwd_load),
        .pkt_i    (fwd_pkt),
        .valid_o  (mem_req_valid),
        .pkt_o    (mem_pkt),
        .accept_i (mem_req_accept),
        .retry_i  (mem_req_retry),
        .held_o   (mem_held)
    );

    assign {mem_req_ifetch, mem_req_cmd, mem_req_addr, mem_req_data} = mem_pkt;

    // Map the per-port response handshake inputs.
    assign rsp_accept[PORT_FCH] = fch_rsp_accept;
    assign rsp_accept[PORT_DAT] = dat_rsp_accept;
    assign rsp_retry[PORT_FCH]  = fch_rsp_retry;
    assign rsp_retry[PORT_DAT]  = dat_rsp_retry;

    // One response sender per requester port, selected by the fetch tag.
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_rsp
        localparam logic IS_FCH = (g == PORT_FCH);
        assign rsp_load[g] = mem_rsp_valid && (mem_rsp_ifetch == IS_FCH);

        fwd_rsp_tx #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_rsp_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (rsp_load[g]),
            .addr_i   (mem_rsp_addr),
            .cmd_i    (mem_rsp_cmd),
            .data_i   (mem_rsp_data),
            .valid_o  (rsp_valid[g]),
            .addr_o   (rsp_addr[g]),
            .cmd_o    (rsp_cmd[g]),
            .data_o   (rsp_data[g]),
            .accept_i (rsp_accept[g]),
            .retry_i  (rsp_retry[g]),
            .occ_o    (rsp_occ[g])
        );
    end

    assign fch_rsp_valid = rsp_valid[PORT_FCH];
    assign fch_rsp_addr  = rsp_addr[PORT_FCH];
    assign fch_rsp_cmd   = rsp_cmd[PORT_FCH];
    assign fch_rsp_data  = rsp_data[PORT_FCH];
    assign dat_rsp_valid = rsp_valid[PORT_DAT];
    assign dat_rsp_addr  = rsp_addr[PORT_DAT];
    assign dat_rsp_cmd   = rsp_cmd[PORT_DAT];
    assign dat_rsp_data  = rsp_data[PORT_DAT];
endmodule

// File: rtl/fwd_checker.sv
// Protocol checker for dual_req_forwarder, bound into the top module.
module fwd_checker #(
    parameter int NPORT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_i,
    input logic             fwd_load_i,
    input logic             mem_held_i,
    input logic [NPORT-1:0] rsp_occ_i,
    input logic [NPORT-1:0] rsp_load_i,
    input logic [NPORT-1:0] req_accept_i,
    input logic [NPORT-1:0] req_retry_i,
    input logic             mem_req_valid_i,
    input logic             mem_req_accept_i,
    input logic             mem_rsp_valid_i,
    input logic [NPORT-1:0] rsp_valid_i,
    input logic [NPORT-1:0] rsp_accept_i
);
    // R5: sending while a packet sits in the blocked register is an error.
    assert_no_send_while_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_load_i |-> !mem_held_i);

    // R5: a refused memory offer is not repeated in the next cycle.
    assert_mem_refuse_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_i && !mem_req_accept_i) |=> !mem_req_valid_i);

    // R6: a memory response only arrives for an outstanding transaction.
    assert_rsp_only_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid_i |-> busy_i);

    // R2: an accepted request leaves the block busy.
    assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_accept_i) |=> busy_i);

    // R4: at most one requester is accepted per cycle.
    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_accept_i));

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        // R9: retry is a single-cycle pulse.
        assert_retry_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            req_retry_i[g] |=> !req_retry_i[g]);

        // R8: a refused response is not repeated in the next cycle.
        assert_rsp_refuse_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid_i[g] && !rsp_accept_i[g]) |=> !rsp_valid_i[g]);

        // R7: a response never lands on a slot that is still occupied.
        assert_rsp_slot_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_load_i[g] |-> !rsp_occ_i[g]);
    end
endmodule

bind dual_req_forwarder fwd_checker #(
    .NPORT (fwd_pkg::NUM_REQ)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .busy_i           (busy),
    .fwd_load_i       (fwd_load),
    .mem_held_i       (mem_held),
    .rsp_occ_i        (rsp_occ),
    .rsp_load_i       (rsp_load),
    .req_accept_i     (req_accept),
    .req_retry_i      (req_retry),
    .mem_req_valid_i  (mem_req_valid),
    .mem_req_accept_i (mem_req_accept),
    .mem_rsp_valid_i  (mem_rsp_valid),
    .rsp_valid_i      (rsp_valid),
    .rsp_accept_i     (rsp_accept)
);

// File: tb/dual_req_forwarder_tb.sv
module dual_req_forwarder_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MW = 1 + 2 + AW + DW;
    localparam int RW = 2 + AW + DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic fch_req_valid = 0, dat_req_valid = 0;
    logic [AW-1:0] fch_req_addr = 0, dat_req_addr = 0;
    logic [1:0] fch_req_cmd = 0, dat_req_cmd = 0;
    logic [DW-1:0] fch_req_data = 0, dat_req_data = 0;
    logic fch_req_accept, fch_req_retry, dat_req_accept, dat_req_retry;
    logic fch_rsp_valid, dat_rsp_valid;
    logic [AW-1:0] fch_rsp_addr, dat_rsp_addr;
    logic [1:0] fch_rsp_cmd, dat_rsp_cmd;
    logic [DW-1:0] fch_rsp_data, dat_rsp_data;
    logic fch_rsp_accept = 1, fch_rsp_retry = 0, dat_rsp_accept = 1, dat_rsp_retry = 0;
    logic mem_req_valid, mem_req_ifetch;
    logic [AW-1:0] mem_req_addr;
    logic [1:0] mem_req_cmd;
    logic [DW-1:0] mem_req_data;
    logic mem_req_accept = 1, mem_req_retry = 0;
    logic mem_rsp_valid = 0, mem_rsp_ifetch = 0;
    logic [AW-1:0] mem_rsp_addr = 0;
    logic [1:0] mem_rsp_cmd = 0;
    logic [DW-1:0] mem_rsp_data = 0;

    dual_req_forwarder #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    int n_checks = 0;
    int n_errors = 0;
    logic [MW-1:0] exp_mem[$];
    logic [RW-1:0] exp_fch[$];
    logic [RW-1:0] exp_dat[$];

    task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitors: compare every offer with the head of its scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid) begin
                if (exp_mem.size() == 0) check_eq("R2", "unexpected mem offer", 1, 0);
                else begin
                    check_eq("R2", "mem packet",
                             {mem_req_ifetch, mem_req_cmd, mem_req_addr, mem_req_data}, exp_mem[0]);
                    if (mem_req_accept) void'(exp_mem.pop_front());
                end
            end
            if (fch_rsp_valid) begin
                if (exp_fch.size() == 0) check_eq("R7", "unexpected fch response", 1, 0);
                else begin
                    check_eq("R7", "fch response", {fch_rsp_cmd, fch_rsp_addr, fch_rsp_data}, exp_fch[0]);
                    if (fch_rsp_accept) void'(exp_fch.pop_front());
                end
            end
            if (dat_rsp_valid) begin
                if (exp_dat.size() == 0) check_eq("R7", "unexpected dat response", 1, 0);
                else begin
                    check_eq("R7", "dat response", {dat_rsp_cmd, dat_rsp_addr, dat_rsp_data}, exp_dat[0]);
                    if (dat_rsp_accept) void'(exp_dat.pop_front());
                end
            end
        end
    end

    // Driver: offer one request for one cycle and check the same-cycle answer.
    task automatic send_req(bit is_fch, logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] d,
                            bit exp_acc, string req);
        if (is_fch) begin
            fch_req_valid = 1; fch_req_cmd = cmd; fch_req_addr = a; fch_req_data = d;
        end else begin
            dat_req_valid = 1; dat_req_cmd = cmd; dat_req_addr = a; dat_req_data = d;
        end
        if (exp_acc) exp_mem.push_back({is_fch, cmd, a, d});
        @(negedge clk);
        check_eq(req, "request accept", is_fch ? fch_req_accept : dat_req_accept, exp_acc);
        step();
        fch_req_valid = 0;
        dat_req_valid = 0;
    endtask

    // Memory model: return one response for one cycle.
    task automatic mem_respond(bit tag, logic [1:0] cmd, logic [AW-1:0] a, logic [DW-1:0] d);
        mem_rsp_valid = 1; mem_rsp_ifetch = tag; mem_rsp_cmd = cmd;
        mem_rsp_addr = a; mem_rsp_data = d;
        if (tag) exp_fch.push_back({cmd | 2'b10, a, d});
        else     exp_dat.push_back({cmd | 2'b10, a, d});
        @(negedge clk);
        step();
        mem_rsp_valid = 0;
    endtask

    bit done = 0;

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "outputs in reset",
                 {mem_req_valid, fch_rsp_valid, dat_rsp_valid, fch_req_retry, dat_req_retry,
                  fch_req_accept, dat_req_accept}, 0);
        step();
        rst_n = 1;
        step();
        @(negedge clk);
        check_eq("R1", "outputs after reset",
                 {mem_req_valid, fch_rsp_valid, dat_rsp_valid, fch_req_retry, dat_req_retry}, 0);
        step();

        // R2, R7: fetch read round trip.
        send_req(1, 2'b00, 16'h0100, 32'h0, 1, "R2");
        step();
        mem_respond(1, 2'b00, 16'h0100, 32'hA5A5_0001);
        step(); step();
        check_eq("R7", "fch queue drained", exp_fch.size(), 0);

        // R2, R7: data write round trip, command becomes 2'b11.
        send_req(0, 2'b01, 16'h0204, 32'hDEAD_BEEF, 1, "R2");
        step();
        mem_respond(0, 2'b01, 16'h0204, 32'hDEAD_BEEF);
        step(); step();
        check_eq("R7", "dat queue drained", exp_dat.size(), 0);

        // R3, R9: refusal while busy, retry after unblock.
        send_req(1, 2'b00, 16'h0300, 32'h0, 1, "R2");
        send_req(0, 2'b00, 16'h0304, 32'h0, 0, "R3");
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_eq("R9", "no retry while busy", dat_req_retry, 0);
            step();
        end
        mem_respond(1, 2'b00, 16'h0300, 32'h3333_3333);
        @(negedge clk);
        check_eq("R9", "dat retry pulse", dat_req_retry, 1);
        check_eq("R9", "no fch retry without refusal", fch_req_retry, 0);
        step();
        @(negedge clk);
        check_eq("R9", "dat retry is one cycle", dat_req_retry, 0);
        step();
        send_req(0, 2'b00, 16'h0304, 32'h0, 1, "R9");
        step();
        mem_respond(0, 2'b00, 16'h0304, 32'h4444_4444);
        step(); step();

        // R4: simultaneous offers, fetch wins.
        fch_req_valid = 1; fch_req_cmd = 2'b00; fch_req_addr = 16'h0400; fch_req_data = 0;
        dat_req_valid = 1; dat_req_cmd = 2'b01; dat_req_addr = 16'h0408; dat_req_data = 32'h0808;
        exp_mem.push_back({1'b1, 2'b00, 16'h0400, 32'h0});
        @(negedge clk);
        check_eq("R4", "fch wins", fch_req_accept, 1);
        check_eq("R4", "dat refused", dat_req_accept, 0);
        step();
        fch_req_valid = 0; dat_req_valid = 0;
        step();
        mem_respond(1, 2'b00, 16'h0400, 32'h4040_4040);
        @(negedge clk);
        check_eq("R4", "loser gets retry", dat_req_retry, 1);
        step();
        send_req(0, 2'b01, 16'h0408, 32'h0808, 1, "R4");
        step();
        mem_respond(0, 2'b01, 16'h0408, 32'h0808);
        step(); step();

        // R5: bus refusal, hold, and resend only after retry.
        mem_req_accept = 0;
        send_req(1, 2'b01, 16'h0500, 32'h5555, 1, "R2");
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_eq("R5", "no offer while held", mem_req_valid, 0);
            step();
        end
        mem_req_retry = 1;
        @(negedge clk);
        check_eq("R5", "no offer in retry cycle", mem_req_valid, 0);
        step();
        mem_req_retry = 0;
        @(negedge clk);
        check_eq("R5", "resend after retry", mem_req_valid, 1);
        step();
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check_eq("R5", "held again after second refusal", mem_req_valid, 0);
            step();
        end
        mem_req_retry = 1;
        mem_req_accept = 1;
        step();
        mem_req_retry = 0;
        step();
        check_eq("R5", "held packet delivered", exp_mem.size(), 0);
        mem_respond(1, 2'b01, 16'h0500, 32'h5555);
        step(); step();

        // R6: request accepted in the cycle the response arrives.
        send_req(0, 2'b00, 16'h0600, 32'h0, 1, "R2");
        step();
        mem_rsp_valid = 1; mem_rsp_ifetch = 0; mem_rsp_cmd = 2'b00;
        mem_rsp_addr = 16'h0600; mem_rsp_data = 32'h6060_6060;
        exp_dat.push_back({2'b10, 16'h0600, 32'h6060_6060});
        fch_req_valid = 1; fch_req_cmd = 2'b00; fch_req_addr = 16'h0610; fch_req_data = 0;
        exp_mem.push_back({1'b1, 2'b00, 16'h0610, 32'h0});
        @(negedge clk);
        check_eq("R6", "accept on response cycle", fch_req_accept, 1);
        step();
        mem_rsp_valid = 0; fch_req_valid = 0;
        step();
        mem_respond(1, 2'b00, 16'h0610, 32'h6161_6161);
        step(); step();

        // R8, R9: held response delays the fetch port's retry.
        fch_rsp_accept = 0;
        send_req(1, 2'b00, 16'h0700, 32'h0, 1, "R2");
        send_req(1, 2'b00, 16'h0704, 32'h0, 0, "R3");
        mem_respond(1, 2'b00, 16'h0700, 32'h7777_7777);
        @(negedge clk);
        check_eq("R8", "response offered", fch_rsp_valid, 1);
        check_eq("R9", "no retry with response pending", fch_req_retry, 0);
        step();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_eq("R8", "no offer while held", fch_rsp_valid, 0);
            check_eq("R9", "no retry while response held", fch_req_retry, 0);
            step();
        end
        fch_rsp_retry = 1;
        fch_rsp_accept = 1;
        step();
        fch_rsp_retry = 0;
        @(negedge clk);
        check_eq("R8", "response re-offered after retry", fch_rsp_valid, 1);
        check_eq("R9", "no retry during delivery", fch_req_retry, 0);
        step();
        @(negedge clk);
        check_eq("R9", "fch retry after drain", fch_req_retry, 1);
        step();
        @(negedge clk);
        check_eq("R9", "fch retry is one cycle", fch_req_retry, 0);
        step();
        send_req(1, 2'b00, 16'h0704, 32'h0, 1, "R9");
        step();
        mem_respond(1, 2'b00, 16'h0704, 32'h7070_7070);
        step(); step();

        check_eq("R2", "mem queue empty", exp_mem.size(), 0);
        check_eq("R7", "fch queue empty", exp_fch.size(), 0);
        check_eq("R7", "dat queue empty", exp_dat.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule